// File: doc/BRIEF.md
# Stateful Resistive-Cell Row Model

This block is a cycle-accurate digital model of one word line in a passive crossbar of complementary resistive switch cells. Each cell holds one bit and behaves as a two-state machine (`CELL_ZERO`, `CELL_ONE`). Every clock cycle the row receives one shared word-line level and a separate 2-bit drive code for each bit line. Each bit line can be driven to ground, to logic 0 or to logic 1. A cell whose bit line is grounded stays as it is. Any other cell updates by the stateful implication rule, so many cells can compute in the same cycle from the same word-line value.

A cell moves from `CELL_ZERO` to `CELL_ONE` (transition SET) only when the word line is 1 and its bit line is 0. It moves from `CELL_ONE` to `CELL_ZERO` (transition RESET) only when the word line is 0 and its bit line is 1. Every other case is transition HOLD. When `rd_en` is asserted, the row performs a destructive read: the word line is forced to 1 and every bit line to logic 0. A cell that switches during the read reports a spike, which means it held 0. Every cell ends the read in `CELL_ONE`.

A small report machine with states `RO_IDLE` and `RO_REPORT` turns the spikes into read data. It enters `RO_REPORT` on the edge that performs a read (transition CAPTURE) and returns to `RO_IDLE` otherwise (transition RELEASE). The per-cell event flags and the current cell states are exposed for observation.

Top module: `crs_row`

## Requirements
- R1: While `rst` is high at a clock edge, every cell goes to 1, `evt_flag` goes to 0 and `rd_valid` goes to 0.
- R2: A cell holding 0 becomes 1 only when the effective word line is 1 and its drive code is 2'b01 (logic 0). Otherwise it stays at 0.
- R3: A cell holding 1 becomes 0 only when the effective word line is 0 and its drive code is 2'b10 (logic 1). Otherwise it stays at 1.
- R4: A drive code of 2'b00 (ground) or 2'b11 (treated as ground) leaves that cell unchanged, whatever the word-line level.
- R5: `evt_flag[i]` is 1 in the cycle after an edge exactly when cell i changed state at that edge.
- R6: When `rd_en` is high, `wl_in` and `bl_drv` are ignored. On the next cycle `rd_valid` is 1 and `rd_data[i]` equals the bit cell i held before the read (1 when no switching event occurred).
- R7: After a read edge, every cell holds 1.
- R8: Cells on the row update independently in the same cycle, each from the shared word line and its own drive code (cell i uses `bl_drv[2i+1:2i]`).
- R9: `rd_valid` is 0 in any cycle that does not follow a read edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Destructive read of the whole row this cycle |
| wl_in | input | 1 | Shared word-line level |
| bl_drv | input | 2*COLS | Per-cell drive code: 00 ground, 01 logic 0, 10 logic 1, 11 ground |
| cell_state | output | COLS | Current bit held by each cell |
| evt_flag | output | COLS | Cell switched at the last edge |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | COLS | Bits recovered by the last read |

## Verification
The embedded properties check, on every cycle, four things: that SET and RESET occur only under their word-line and drive conditions, that grounded cells hold, that an event flag coincides with a real state change, and that every read returns the prior row contents and leaves all cells at 1. Only the bench scenarios can show that the row computes the right next value for every combination of state, word-line level and drive code. They also show that several cells with different codes behave independently in one cycle, and that the read override masks arbitrary `wl_in` and `bl_drv` values.

// File: rtl/crs_row_pkg.sv
package crs_row_pkg;

    typedef enum logic [1:0] {
        DRV_GND = 2'b00,
        DRV_LO  = 2'b01,
        DRV_HI  = 2'b10,
        DRV_RSV = 2'b11
    } drive_e;

    typedef enum logic {
        CELL_ZERO = 1'b0,
        CELL_ONE  = 1'b1
    } cell_e;

    typedef enum logic {
        RO_IDLE   = 1'b0,
        RO_REPORT = 1'b1
    } report_e;

endpackage

// File: rtl/crs_row_drive.sv
module crs_row_drive
    import crs_row_pkg::*;
#(
    parameter int COLS = 8
) (
    input  logic                rd_en,
    input  logic                wl_in,
    input  logic [2*COLS-1:0]   bl_drv,
    output logic                wl_eff,
    output logic [2*COLS-1:0]   drv_eff
);

    // A read forces the word line high and every bit line to logic 0.
    assign wl_eff = rd_en | wl_in;

    for (genvar g = 0; g < COLS; g++) begin : g_drv
        assign drv_eff[2*g +: 2] = rd_en ? DRV_LO : bl_drv[2*g +: 2];
    end

endmodule

// File: rtl/crs_row_cell.sv
module crs_row_cell
    import crs_row_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wl,
    input  logic [1:0] drv,
    output logic       state_o,
    output logic       spike_o,
    output logic       evt_o
);

    cell_e state_q;
    cell_e state_nx;
    logic  bl_act;
    logic  bl_val;
    logic  evt_q;

    // Bit-line decode: ground and the spare code leave the cell floating.
    always_comb begin
        unique case (drv)
            DRV_LO:  begin bl_act = 1'b1; bl_val = 1'b0; end
            DRV_HI:  begin bl_act = 1'b1; bl_val = 1'b1; end
            DRV_GND: begin bl_act = 1'b0; bl_val = 1'b0; end
            DRV_RSV: begin bl_act = 1'b0; bl_val = 1'b0; end
        endcase
    end

    // Next-state process: reverse implication from one, inverse implication from zero.
    always_comb begin
        state_nx = state_q;
        if (bl_act) begin
            unique case (state_q)
                CELL_ONE:  state_nx = (wl | ~bl_val) ? CELL_ONE : CELL_ZERO;
                CELL_ZERO: state_nx = (wl & ~bl_val) ? CELL_ONE : CELL_ZERO;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CELL_ONE;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            evt_q   <= (state_nx != state_q);
        end
    end

    assign state_o = state_q;
    assign spike_o = (state_nx != state_q);
    assign evt_o   = evt_q;

    // R2
    set_cond_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_o) |-> ($past(wl) && $past(drv) == DRV_LO));

    // R3
    reset_cond_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(state_o) |-> (!$past(wl) && $past(drv) == DRV_HI));

    // R4
    ground_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drv == DRV_GND || drv == DRV_RSV) |=> $stable(state_o));

    // R5
    evt_change_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> (state_o != $past(state_o)));

endmodule

// File: rtl/crs_row_report.sv
module crs_row_report
    import crs_row_pkg::*;
#(
    parameter int COLS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_en,
    input  logic [COLS-1:0] spike,
    output logic            rd_valid,
    output logic [COLS-1:0] rd_data
);

    report_e st_q;
    report_e st_nx;
    logic [COLS-1:0] data_q;

    // Transition process: CAPTURE on a read edge, RELEASE otherwise.
    always_comb begin
        unique case (st_q)
            RO_IDLE:   st_nx = rd_en ? RO_REPORT : RO_IDLE;
            RO_REPORT: st_nx = rd_en ? RO_REPORT : RO_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) st_q <= RO_IDLE;
        else     st_q <= st_nx;
    end

    // Output process: a spike during a read means the cell held zero.
    always_ff @(posedge clk) begin
        if (rst)        data_q <= '0;
        else if (rd_en) data_q <= ~spike;
    end

    assign rd_valid = (st_q == RO_REPORT);
    assign rd_data  = data_q;

endmodule

// File: rtl/crs_row.sv
module crs_row
    import crs_row_pkg::*;
#(
    parameter int COLS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic                wl_in,
    input  logic [2*COLS-1:0]   bl_drv,
    output logic [COLS-1:0]     cell_state,
    output logic [COLS-1:0]     evt_flag,
    output logic                rd_valid,
    output logic [COLS-1:0]     rd_data
);

    logic                wl_eff;
    logic [2*COLS-1:0]   drv_eff;
    logic [COLS-1:0]     spike;

    crs_row_drive #(.COLS(COLS)) u_drive (
        .rd_en   (rd_en),
        .wl_in   (wl_in),
        .bl_drv  (bl_drv),
        .wl_eff  (wl_eff),
        .drv_eff (drv_eff)
    );

    for (genvar g = 0; g < COLS; g++) begin : g_cell
        crs_row_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .wl      (wl_eff),
            .drv     (drv_eff[2*g +: 2]),
            .state_o (cell_state[g]),
            .spike_o (spike[g]),
            .evt_o   (evt_flag[g])
        );
    end

    crs_row_report #(.COLS(COLS)) u_report (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .spike    (spike),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R6
    read_data_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data == $past(cell_state)));

    // R7
    read_ones_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (&cell_state));

    // R9
    valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en));

endmodule

// File: tb/crs_row_test.sv
module crs_row_test;

    localparam int COLS = 8;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                rd_en = 1'b0;
    logic                wl_in = 1'b0;
    logic [2*COLS-1:0]   bl_drv = '0;
    logic [COLS-1:0]     cell_state;
    logic [COLS-1:0]     evt_flag;
    logic                rd_valid;
    logic [COLS-1:0]     rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [COLS-1:0] m_state;
    logic [COLS-1:0] m_evt;
    logic [COLS-1:0] m_rdd;
    logic            m_rdv;

    always #2.5 clk = ~clk;

    crs_row #(.COLS(COLS)) uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wl_in(wl_in), .bl_drv(bl_drv),
        .cell_state(cell_state), .evt_flag(evt_flag),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model of one edge, written from the requirements.
    task automatic model_edge(input logic rd, input logic wl, input logic [2*COLS-1:0] drv);
        for (int i = 0; i < COLS; i++) begin
            logic s, w, act, b, nx;
            s = m_state[i];
            if (rd) begin
                w = 1'b1; act = 1'b1; b = 1'b0;
            end else begin
                w = wl;
                act = (drv[2*i +: 2] == 2'b01) || (drv[2*i +: 2] == 2'b10);
                b = (drv[2*i +: 2] == 2'b10);
            end
            if (!act)    nx = s;
            else if (s)  nx = w | ~b;
            else         nx = w & ~b;
            m_evt[i] = (nx != s);
            if (rd) m_rdd[i] = s;
            m_state[i] = nx;
        end
        m_rdv = rd;
    endtask

    task automatic step(input logic rd, input logic wl, input logic [2*COLS-1:0] drv,
                        input string tag);
        rd_en = rd; wl_in = wl; bl_drv = drv;
        model_edge(rd, wl, drv);
        @(posedge clk); #1;
        chk({tag, " state"}, 64'(cell_state), 64'(m_state));
        chk("R5 event", 64'(evt_flag), 64'(m_evt));
        chk("R6/R9 valid", 64'(rd_valid), 64'(m_rdv));
        if (m_rdv) begin
            chk("R6 data", 64'(rd_data), 64'(m_rdd));
            chk("R7 ones", 64'(cell_state), 64'({COLS{1'b1}}));
        end
    endtask

    function automatic logic [2*COLS-1:0] all_code(input logic [1:0] c);
        for (int i = 0; i < COLS; i++) all_code[2*i +: 2] = c;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 state", 64'(cell_state), 64'({COLS{1'b1}}));
        chk("R1 event", 64'(evt_flag), 64'(0));
        chk("R1 valid", 64'(rd_valid), 64'(0));
        m_state = '1; m_evt = '0; m_rdd = '0; m_rdv = 1'b0;
        rst = 1'b0;

        // R3: RESET needs wl=0 and logic 1
        step(1'b0, 1'b1, all_code(2'b10), "R3 wl1 hold");
        step(1'b0, 1'b0, all_code(2'b10), "R3 clear");
        // R2: SET needs wl=1 and logic 0
        step(1'b0, 1'b0, all_code(2'b01), "R2 wl0 hold");
        step(1'b0, 1'b1, all_code(2'b10), "R2 hi hold");
        step(1'b0, 1'b1, all_code(2'b01), "R2 set");
        // R4: ground and spare code hold, any word line
        step(1'b0, 1'b0, all_code(2'b00), "R4 gnd wl0");
        step(1'b0, 1'b0, all_code(2'b11), "R4 rsv wl0");
        step(1'b0, 1'b0, all_code(2'b10), "R3 clear");
        step(1'b0, 1'b1, all_code(2'b00), "R4 gnd wl1");
        step(1'b0, 1'b1, all_code(2'b11), "R4 rsv wl1");
        // R8: mixed codes in one cycle
        step(1'b0, 1'b0, 16'b10_01_00_11_10_01_00_11, "R8 mix wl0");
        step(1'b0, 1'b1, 16'b01_01_10_00_11_01_10_01, "R8 mix wl1");
        // R6/R7: read masks inputs, returns prior contents
        step(1'b1, 1'b0, all_code(2'b10), "R6 read");
        step(1'b0, 1'b0, 16'b10_00_10_00_10_00_10_00, "R9 idle");
        step(1'b1, 1'b0, all_code(2'b11), "R6 read2");
        step(1'b1, 1'b0, all_code(2'b10), "R6 back to back");

        // Near-exhaustive sweep: every state/wl/code combination many times
        lf = 16'hACE1;
        for (int t = 0; t < 3000; t++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step((t % 9) == 8, lf[0], {lf[15:1], lf[15] ^ lf[0]}, "R2/R3/R4/R8 sweep");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule